// File: doc/BRIEF.md
# Interrupt Trigger Conditioning Unit

This block takes a wide vector of asynchronous interrupt inputs and turns each line into a clean request. Every line has two configuration bits, called rise and fall. Together they choose one of four modes: active-high level, active-low level, rising edge or falling edge. Inputs pass through a two-flop synchronizer. After that, each line either follows its polarity-corrected level, or catches the selected transition in a sticky raw-status bit. Software clears a sticky bit by writing a one to it.

Lines are grouped into banks of 32. Each bank has one 32-byte window on a small register bus. A write takes effect on a clock edge when the write enable is high. A read is combinational from the address. Each bank window holds a status view, a raw-status view with write-one-to-clear, direct rise and fall config registers, and set and clear aliases for each config register. With an alias, one line's mode can change without a read-modify-write of the whole register.

Top module: `irq_trigger_cond`

## Requirements
- R1: After reset, every rise and fall config bit reads 0, so all lines start in active-high level mode, and `irq_out` is all zeros while the inputs are low.
- R2: In level mode, a change on `irq_in` reaches `irq_out` on the second rising clock edge after the change, not on the first.
- R3: With rise=0 and fall=0, `irq_out` for that line equals the synchronized input.
- R4: With rise=1 and fall=1, `irq_out` for that line equals the inverted synchronized input.
- R5: With rise=1 and fall=0, a 0-to-1 input transition sets the line's sticky bit, and the bit stays set after the input returns low. 1-to-0 transitions set nothing.
- R6: With rise=0 and fall=1, a 1-to-0 input transition sets the sticky bit. 0-to-1 transitions set nothing.
- R7: Writing to the raw-status offset 0x04 clears each sticky bit whose data bit is 1. Bits written as 0 are unchanged, and writing all ones clears every pending edge of that bank only.
- R8: If an edge is detected in the same cycle as a clear of that bit, the bit stays set.
- R9: The rise config sits at offset 0x08, with a write-one-to-set alias at 0x10 and a write-one-to-clear alias at 0x14. The fall config sits at 0x0C, with aliases at 0x18 and 0x1C. The direct offsets take a full write and read back what was written.
- R10: Bank b occupies addresses b*0x20 to b*0x20+0x1F. Line 32*b+k is bit k of that bank. Offset 0x00 returns `irq_out` for the bank's lines.
- R11: Offset 0x04 returns the sticky bit for edge-mode lines and the polarity-corrected level for level-mode lines.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_in | input | 64 | Raw asynchronous interrupt lines |
| irq_out | output | 64 | Conditioned request per line |
| reg_addr | input | 8 | Byte address for register access |
| reg_we | input | 1 | Write strobe, sampled on the clock edge |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational from `reg_addr` |

## Verification
The bench drives single-line stimulus in each of the four modes. It also exposes each mode to the transition it must ignore: a falling edge on a rising-mode line, a rising edge on a falling-mode line, and a level held after the edge. This separates sticky latching from level following and shows whether the direction decode is swapped. Lines are placed in both banks, so a bit that lands in the wrong bank or at the wrong position is caught. A clear is timed to land exactly on the edge-detection cycle, which separates "edge wins" from "clear wins". Sampling one cycle early and one cycle on time pins down the synchronizer depth.

// File: rtl/irq_trigger_cond.sv
module irq_trigger_cond #(
  parameter int NUM_LINES = 64,
  parameter int BANK_W    = 32,
  parameter int ADDR_W    = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] irq_in,
  output logic [NUM_LINES-1:0] irq_out,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic                 reg_we,
  input  logic [BANK_W-1:0]    reg_wdata,
  output logic [BANK_W-1:0]    reg_rdata
);
  localparam int NUM_BANKS = NUM_LINES / BANK_W;
  localparam int BSEL_W    = ADDR_W - 5;

  logic [NUM_LINES-1:0] sync1_q, sync2_q, prev_q;
  logic [NUM_LINES-1:0] rise_q, fall_q, raw_q;
  logic [NUM_LINES-1:0] clr_vec, evt, edge_m, lvl;
  logic [2:0]           off;
  logic [BSEL_W-1:0]    bsel;

  assign off  = reg_addr[4:2];
  assign bsel = reg_addr[ADDR_W-1:5];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= irq_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign edge_m = rise_q ^ fall_q;
  assign lvl    = sync2_q ^ (rise_q & fall_q);
  assign evt    = (rise_q & ~fall_q & sync2_q & ~prev_q)
                | (~rise_q & fall_q & ~sync2_q & prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) raw_q <= '0;
    else        raw_q <= edge_m & ((raw_q & ~clr_vec) | evt);
  end

  assign irq_out = (edge_m & raw_q) | (~edge_m & lvl);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam logic [BSEL_W-1:0] BIDX = BSEL_W'(b);
    logic hit_wr;
    assign hit_wr = reg_we && (bsel == BIDX);
    assign clr_vec[b*BANK_W +: BANK_W] = (hit_wr && off == 3'd1) ? reg_wdata : '0;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rise_q[b*BANK_W +: BANK_W] <= '0;
        fall_q[b*BANK_W +: BANK_W] <= '0;
      end else if (hit_wr) begin
        case (off)
          3'd2: rise_q[b*BANK_W +: BANK_W] <= reg_wdata;
          3'd3: fall_q[b*BANK_W +: BANK_W] <= reg_wdata;
          3'd4: rise_q[b*BANK_W +: BANK_W] <= rise_q[b*BANK_W +: BANK_W] | reg_wdata;
          3'd5: rise_q[b*BANK_W +: BANK_W] <= rise_q[b*BANK_W +: BANK_W] & ~reg_wdata;
          3'd6: fall_q[b*BANK_W +: BANK_W] <= fall_q[b*BANK_W +: BANK_W] | reg_wdata;
          3'd7: fall_q[b*BANK_W +: BANK_W] <= fall_q[b*BANK_W +: BANK_W] & ~reg_wdata;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    reg_rdata = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bsel == BSEL_W'(b)) begin
        case (off)
          3'd0, 3'd1: reg_rdata = irq_out[b*BANK_W +: BANK_W];
          3'd2:       reg_rdata = rise_q[b*BANK_W +: BANK_W];
          3'd3:       reg_rdata = fall_q[b*BANK_W +: BANK_W];
          default:    reg_rdata = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/irq_trigger_cond_chk.sv
module irq_trigger_cond_chk #(
  parameter int N = 64
) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] irq_in,
  input logic [N-1:0] irq_out,
  input logic [N-1:0] rise_q,
  input logic [N-1:0] fall_q,
  input logic [N-1:0] clr_vec
);
  logic [2:0] cyc;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cyc <= '0;
    else if (cyc != 7) cyc <= cyc + 3'd1;
  end

  AST_LEVEL_HIGH: assert property (@(posedge clk) disable iff (!rst_n || cyc < 3)
    ((~rise_q & ~fall_q) & (irq_out ^ $past(irq_in, 2))) == '0); // R3

  AST_LEVEL_LOW: assert property (@(posedge clk) disable iff (!rst_n || cyc < 3)
    ((rise_q & fall_q) & (irq_out ^ ~$past(irq_in, 2))) == '0); // R4

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n || cyc < 2)
    ($past(irq_out) & (rise_q ^ fall_q) & $past(rise_q ^ fall_q) & ~$past(clr_vec) & ~irq_out) == '0); // R7

  AST_RISE_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rst_n || cyc < 6)
    (irq_out & ~$past(irq_out) & rise_q & ~fall_q & $past(rise_q & ~fall_q)
      & ~($past(irq_in, 3) & ~$past(irq_in, 4))) == '0); // R5
endmodule

bind irq_trigger_cond irq_trigger_cond_chk #(.N(NUM_LINES)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
  .rise_q(rise_q), .fall_q(fall_q), .clr_vec(clr_vec)
);

// File: tb/irq_trigger_cond_tb.sv
module irq_trigger_cond_tb;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [63:0] irq_in = '0;
  logic [63:0] irq_out;
  logic [7:0]  reg_addr = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  irq_trigger_cond u_dut (
    .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .irq_out(irq_out),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_we = 1;
    @(posedge clk);
    @(negedge clk);
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    chk("R1 out", irq_out, 64'h0);
    rd(8'h08, d); chk("R1 rise b0", {32'h0, d}, 64'h0);
    rd(8'h2C, d); chk("R1 fall b1", {32'h0, d}, 64'h0);
  endtask

  task automatic t_level_high;
    logic [31:0] d;
    @(negedge clk); irq_in[3] = 1;
    @(posedge clk); #1 chk("R2 early", {63'h0, irq_out[3]}, 64'h0);
    @(posedge clk); #1 chk("R2 R3 on time", {63'h0, irq_out[3]}, 64'h1);
    rd(8'h00, d); chk("R10 status b0", {32'h0, d}, 64'h8);
    rd(8'h04, d); chk("R11 raw mirrors level", {32'h0, d}, 64'h8);
    @(negedge clk); irq_in[3] = 0;
    idle(3); chk("R3 low", {63'h0, irq_out[3]}, 64'h0);
  endtask

  task automatic t_level_low;
    logic [31:0] d;
    wr(8'h10, 32'h20); wr(8'h18, 32'h20);
    rd(8'h08, d); chk("R9 rise set", {32'h0, d}, 64'h20);
    chk("R4 inverted low", {63'h0, irq_out[5]}, 64'h1);
    @(negedge clk); irq_in[5] = 1;
    idle(3); chk("R4 inverted high", {63'h0, irq_out[5]}, 64'h0);
    wr(8'h14, 32'h20); wr(8'h1C, 32'h20);
    rd(8'h08, d); chk("R9 rise clr", {32'h0, d}, 64'h0);
    rd(8'h0C, d); chk("R9 fall clr", {32'h0, d}, 64'h0);
    chk("R3 back to high level", {63'h0, irq_out[5]}, 64'h1);
    @(negedge clk); irq_in[5] = 0;
    idle(3);
  endtask

  task automatic t_rising;
    logic [31:0] d;
    wr(8'h30, 32'h100);
    @(negedge clk); irq_in[40] = 1;
    idle(4); chk("R5 latched", {63'h0, irq_out[40]}, 64'h1);
    @(negedge clk); irq_in[40] = 0;
    idle(4); chk("R5 sticky", {63'h0, irq_out[40]}, 64'h1);
    rd(8'h20, d); chk("R10 bank1 bit8", {32'h0, d}, 64'h100);
    wr(8'h24, 32'h100); chk("R7 clear", {63'h0, irq_out[40]}, 64'h0);
    @(negedge clk); irq_in[40] = 1;
    idle(4); wr(8'h24, 32'h100);
    @(negedge clk); irq_in[40] = 0;
    idle(4); chk("R5 falling ignored", {63'h0, irq_out[40]}, 64'h0);
  endtask

  task automatic t_falling;
    wr(8'h18, 32'h80);
    @(negedge clk); irq_in[7] = 1;
    idle(4); chk("R6 rising ignored", {63'h0, irq_out[7]}, 64'h0);
    @(negedge clk); irq_in[7] = 0;
    idle(4); chk("R6 latched", {63'h0, irq_out[7]}, 64'h1);
  endtask

  task automatic t_w1c;
    wr(8'h04, 32'h0);
    chk("R7 zero write keeps", {63'h0, irq_out[7]}, 64'h1);
    @(negedge clk); irq_in[40] = 1;
    idle(4);
    wr(8'h04, 32'hFFFF_FFFF);
    chk("R7 bank0 all ones", {63'h0, irq_out[7]}, 64'h0);
    chk("R7 R10 bank1 untouched", {63'h0, irq_out[40]}, 64'h1);
    wr(8'h24, 32'hFFFF_FFFF);
    chk("R7 bank1 all ones", {63'h0, irq_out[40]}, 64'h0);
    @(negedge clk); irq_in[40] = 0;
    idle(3);
  endtask

  task automatic t_collision;
    @(negedge clk); irq_in[7] = 1;
    idle(4);
    @(negedge clk); irq_in[7] = 0;
    idle(4);
    @(negedge clk); irq_in[7] = 1;
    idle(4);
    chk("R8 pre latched", {63'h0, irq_out[7]}, 64'h1);
    @(negedge clk); irq_in[7] = 0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); reg_addr = 8'h04; reg_wdata = 32'h80; reg_we = 1;
    @(posedge clk);
    @(negedge clk); reg_we = 0;
    chk("R8 edge wins", {63'h0, irq_out[7]}, 64'h1);
    wr(8'h04, 32'h80);
    chk("R8 plain clear", {63'h0, irq_out[7]}, 64'h0);
  endtask

  task automatic t_direct;
    logic [31:0] d;
    wr(8'h08, 32'h5A00);
    rd(8'h08, d); chk("R9 direct rise", {32'h0, d}, 64'h5A00);
    wr(8'h2C, 32'h0000_0F00);
    rd(8'h2C, d); chk("R9 direct fall b1", {32'h0, d}, 64'h0F00);
    rd(8'h0C, d); chk("R9 R10 fall b0", {32'h0, d}, 64'h80);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    t_reset();
    t_level_high();
    t_level_low();
    t_rising();
    t_falling();
    t_w1c();
    t_collision();
    t_direct();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule